// File: doc/BRIEF.md
# Strobed Handshake Parallel Port Pair

This block provides two parallel ports, A and B, each of which works either as a plain input or output or as a port with a strobe and flag handshake. A six-bit auxiliary port C supplies the handshake lines when they are needed. When they are not needed, its pins are general-purpose bits. A command register sets the direction of ports A and B, the function of port C, and a per-port interrupt enable. A status register reports the flags of both ports.

The block sits behind a bus interface that decodes the processor cycle. That interface hands the block a one-cycle write pulse, a one-cycle read pulse, a two-bit register select and the write data. Read data is returned combinationally for the selected register. In strobed input mode, a peripheral strobe captures the port pins and raises buffer full. The processor's read of the port then clears buffer full. In strobed output mode, the processor's write raises buffer full, and the peripheral's strobe reports that it has taken the data. Strobe inputs are asynchronous, so they are synchronized before use.

Top module: `pp_port_pair`

## Requirements
- R1: After reset the command register is zero, no port pin is driven (`pa_oe`, `pb_oe`, `pc_oe` all zero), and the status read is 0x00.
- R2: Register select 0 writes the command register. Command bit 0 makes port A an output and bit 1 makes port B an output. A write to select 1 (A) or 2 (B) loads that port's output register, which appears on `pa_out`/`pb_out` and reads back while the port is an output.
- R3: A port that is a plain input returns its live pins on a read of its select.
- R4: Command bits [3:2] choose the port C mode: 0 = all six pins inputs, 1 = all six outputs, 2 = port A handshake with pins 3..5 as outputs, 3 = both ports handshake.
- R5: Port C general-purpose pins are written through select 3. A read of select 3 returns, per bit, the driven value when that pin is an output and the pin level when it is an input, with bits 7:6 zero.
- R6: In handshake mode, pin 0/1/2 of port C carry port A's interrupt (out), buffer full (out) and strobe (in). Pins 3/4/5 carry the same three lines for port B.
- R7: In strobed input mode, a rising strobe edge latches the port pins and sets buffer full. A read of the port returns the latched byte even after the pins change.
- R8: In strobed input mode, a processor read of the port clears buffer full and the interrupt.
- R9: In strobed output mode, a processor write to the port sets buffer full and clears the interrupt. A rising strobe edge clears buffer full.
- R10: The interrupt flag is set by a rising strobe edge only when that port's enable is set (command bit 4 for A, bit 5 for B).
- R11: A status read (select 0) returns bit0 A interrupt, bit1 A buffer full, bit2 A enable, bit3 B interrupt, bit4 B buffer full, bit5 B enable, bits 7:6 zero.
- R12: A strobe rising edge at the pin changes the flags exactly three clock edges later: two synchronizer stages, then the flag register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write pulse |
| rd_en | input | 1 | One-cycle read pulse |
| reg_sel | input | 2 | 0 command/status, 1 port A, 2 port B, 3 port C |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A driven value |
| pa_oe | output | 1 | Port A drive enable |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B driven value |
| pb_oe | output | 1 | Port B drive enable |
| pc_in | input | 6 | Port C pin levels |
| pc_out | output | 6 | Port C driven values |
| pc_oe | output | 6 | Port C per-pin drive enable |

## Verification
A corrupted buffer-full or interrupt flag shows up at once at two places: on its port C handshake pin and in the status read. It stays visible until the next read, write or strobe event that should have changed it. A wrong latch value appears at the next read of the port. A wrong mode decode shows up immediately in the `pc_oe` pattern. The bench pins the strobe timing to the exact clock edge, so that an extra or missing synchronizer stage is caught.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_A    = 2'd1,
    SEL_B    = 2'd2,
    SEL_C    = 2'd3
  } reg_sel_t;

  typedef enum logic [1:0] {
    PC_ALL_IN  = 2'd0,
    PC_ALL_OUT = 2'd1,
    PC_HS_A    = 2'd2,
    PC_HS_AB   = 2'd3
  } pc_mode_t;

  typedef struct packed {
    logic [1:0] rsvd;
    logic       ie_b;
    logic       ie_a;
    pc_mode_t   pc_mode;
    logic       dir_b;
    logic       dir_a;
  } cmd_t;

  localparam int unsigned PC_W = 6;
endpackage

// File: rtl/pp_strobe_sync.sv
module pp_strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_raw,
  output logic stb_rise
);
  logic [STAGES:0] chain_q, chain_d;

  always_comb chain_d = {chain_q[STAGES-1:0], stb_raw};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign stb_rise = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/pp_hs_port.sv
module pp_hs_port #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hs_en,
  input  logic          dir_out,
  input  logic          ie,
  input  logic          stb_rise,
  input  logic [DW-1:0] pins_in,
  input  logic          wr_pulse,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_pulse,
  output logic [DW-1:0] out_q,
  output logic [DW-1:0] rd_val,
  output logic          bf_q,
  output logic          intr_q
);
  logic [DW-1:0] out_d, latch_q, latch_d;
  logic          bf_d, intr_d, upd;

  assign upd = wr_pulse | rd_pulse | stb_rise | ~hs_en;

  always_comb begin
    out_d   = out_q;
    latch_d = latch_q;
    bf_d    = bf_q;
    intr_d  = intr_q;
    if (wr_pulse) out_d = wr_data;
    if (!hs_en) begin
      bf_d   = 1'b0;
      intr_d = 1'b0;
    end else if (!dir_out) begin
      if (rd_pulse) begin
        bf_d   = 1'b0;
        intr_d = 1'b0;
      end
      if (stb_rise) begin
        latch_d = pins_in;
        bf_d    = 1'b1;
        intr_d  = ie;
      end
    end else begin
      if (stb_rise) begin
        bf_d   = 1'b0;
        intr_d = ie;
      end
      if (wr_pulse) begin
        bf_d   = 1'b1;
        intr_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      latch_q <= '0;
      bf_q    <= 1'b0;
      intr_q  <= 1'b0;
    end else if (upd) begin
      out_q   <= out_d;
      latch_q <= latch_d;
      bf_q    <= bf_d;
      intr_q  <= intr_d;
    end
  end

  always_comb begin
    if (dir_out)    rd_val = out_q;
    else if (hs_en) rd_val = latch_q;
    else            rd_val = pins_in;
  end

  // R7
  in_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_en && !dir_out && stb_rise) |=> (bf_q && latch_q == $past(pins_in)));
  // R8
  rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_en && !dir_out && rd_pulse && !stb_rise) |=> (!bf_q && !intr_q));
  // R9
  wr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_en && dir_out && wr_pulse) |=> (bf_q && !intr_q));
  // R10
  intr_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intr_q) |-> $past(ie));
endmodule

// File: rtl/pp_port_pair.sv
module pp_port_pair
  import pp_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned SYNC_ST = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [1:0]      reg_sel,
  input  logic [7:0]      wdata,
  output logic [7:0]      rdata,
  input  logic [DW-1:0]   pa_in,
  output logic [DW-1:0]   pa_out,
  output logic            pa_oe,
  input  logic [DW-1:0]   pb_in,
  output logic [DW-1:0]   pb_out,
  output logic            pb_oe,
  input  logic [PC_W-1:0] pc_in,
  output logic [PC_W-1:0] pc_out,
  output logic [PC_W-1:0] pc_oe
);
  localparam int unsigned RDW = (DW > 8) ? DW : 8;

  logic rst_meta_q, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  cmd_t           cmd_q, cmd_d;
  logic [PC_W-1:0] pcg_q, pcg_d;
  logic           cmd_we, pcg_we;

  assign cmd_we = wr_en && (reg_sel == SEL_CTRL);
  assign pcg_we = wr_en && (reg_sel == SEL_C);

  always_comb begin
    cmd_d = cmd_q;
    pcg_d = pcg_q;
    if (cmd_we) cmd_d = cmd_t'(wdata);
    if (pcg_we) pcg_d = wdata[PC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      cmd_q <= '0;
      pcg_q <= '0;
    end else begin
      if (cmd_we) cmd_q <= cmd_d;
      if (pcg_we) pcg_q <= pcg_d;
    end
  end

  logic hs_a, hs_b;
  assign hs_a = (cmd_q.pc_mode == PC_HS_A) || (cmd_q.pc_mode == PC_HS_AB);
  assign hs_b = (cmd_q.pc_mode == PC_HS_AB);

  logic [1:0]      rise;
  logic [1:0]      stb_pin;
  logic [1:0]      bf, intr, hs_en, dir, ie, wr_p, rd_p;
  logic [DW-1:0]   pins   [2];
  logic [DW-1:0]   outv   [2];
  logic [DW-1:0]   rdv    [2];

  assign stb_pin = {pc_in[5], pc_in[2]};
  assign hs_en   = {hs_b, hs_a};
  assign dir     = {cmd_q.dir_b, cmd_q.dir_a};
  assign ie      = {cmd_q.ie_b, cmd_q.ie_a};
  assign pins[0] = pa_in;
  assign pins[1] = pb_in;
  assign wr_p    = {wr_en && (reg_sel == SEL_B), wr_en && (reg_sel == SEL_A)};
  assign rd_p    = {rd_en && (reg_sel == SEL_B), rd_en && (reg_sel == SEL_A)};

  for (genvar p = 0; p < 2; p++) begin : g_port
    pp_strobe_sync #(.STAGES(SYNC_ST)) u_sync (
      .clk      (clk),
      .rst_n    (rst_q),
      .stb_raw  (stb_pin[p]),
      .stb_rise (rise[p])
    );
    pp_hs_port #(.DW(DW)) u_port (
      .clk      (clk),
      .rst_n    (rst_q),
      .hs_en    (hs_en[p]),
      .dir_out  (dir[p]),
      .ie       (ie[p]),
      .stb_rise (rise[p]),
      .pins_in  (pins[p]),
      .wr_pulse (wr_p[p]),
      .wr_data  (wdata[DW-1:0]),
      .rd_pulse (rd_p[p]),
      .out_q    (outv[p]),
      .rd_val   (rdv[p]),
      .bf_q     (bf[p]),
      .intr_q   (intr[p])
    );
  end

  assign pa_out = outv[0];
  assign pb_out = outv[1];
  assign pa_oe  = cmd_q.dir_a;
  assign pb_oe  = cmd_q.dir_b;

  logic [PC_W-1:0] gp_oe, hs_oe, pc_view;
  always_comb begin
    case (cmd_q.pc_mode)
      PC_ALL_OUT: gp_oe = 6'b111111;
      PC_HS_A:    gp_oe = 6'b111000;
      default:    gp_oe = 6'b000000;
    endcase
    hs_oe  = (hs_a ? 6'b000011 : 6'b000000) | (hs_b ? 6'b011000 : 6'b000000);
    pc_oe  = gp_oe | hs_oe;
    pc_out = pcg_q;
    if (hs_a) begin
      pc_out[0] = intr[0];
      pc_out[1] = bf[0];
    end
    if (hs_b) begin
      pc_out[3] = intr[1];
      pc_out[4] = bf[1];
    end
    for (int i = 0; i < PC_W; i++) pc_view[i] = pc_oe[i] ? pc_out[i] : pc_in[i];
  end

  logic [RDW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (reg_sel)
      SEL_CTRL: rd_mux[5:0] = {cmd_q.ie_b, bf[1], intr[1], cmd_q.ie_a, bf[0], intr[0]};
      SEL_A:    rd_mux[DW-1:0] = rdv[0];
      SEL_B:    rd_mux[DW-1:0] = rdv[1];
      default:  rd_mux[PC_W-1:0] = pc_view;
    endcase
  end
  assign rdata = rd_mux[7:0];

  // R6
  hs_strobe_in_chk: assert property (@(posedge clk) disable iff (!rst_q)
    hs_a |-> !pc_oe[2]);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(rst_q) |-> (!pa_oe && !pb_oe && pc_oe == '0));
endmodule

// File: tb/pp_port_pair_test.sv
module pp_port_pair_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, rd_en;
  logic [1:0] reg_sel;
  logic [7:0] wdata, rdata;
  logic [7:0] pa_in, pa_out, pb_in, pb_out;
  logic       pa_oe, pb_oe;
  logic [5:0] pc_in, pc_out, pc_oe;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pp_port_pair uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
    .wdata(wdata), .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pc_in(pc_in),
    .pc_out(pc_out), .pc_oe(pc_oe)
  );

  // fields: [30] op (0 write, 1 read-check), [29:28] sel, [27:20] data,
  //         [19:12] pins, [11:4] expected rdata, [3:0] requirement
  localparam logic [30:0] VEC [12] = '{
    {1'b1, 2'd0, 8'h00, 8'h00, 8'h00, 4'd1},   // R1 status zero
    {1'b1, 2'd1, 8'h00, 8'h5A, 8'h5A, 4'd3},   // R3 A live pins
    {1'b1, 2'd2, 8'h00, 8'h5A, 8'hA5, 4'd3},   // R3 B live pins
    {1'b1, 2'd3, 8'h00, 8'h2D, 8'h2D, 4'd4},   // R4 C all inputs
    {1'b0, 2'd0, 8'h07, 8'h00, 8'h00, 4'd2},   // R2 both out, C out
    {1'b0, 2'd1, 8'h3C, 8'h00, 8'h00, 4'd2},   // R2 load A
    {1'b1, 2'd1, 8'h00, 8'h00, 8'h3C, 4'd2},   // R2 A readback
    {1'b0, 2'd3, 8'h15, 8'h00, 8'h00, 4'd5},   // R5 load C
    {1'b1, 2'd3, 8'h00, 8'h2A, 8'h15, 4'd5},   // R5 C driven view
    {1'b0, 2'd0, 8'h00, 8'h00, 8'h00, 4'd4},   // R4 back to inputs
    {1'b1, 2'd3, 8'h00, 8'h2A, 8'h2A, 4'd4},   // R4 C pins view
    {1'b1, 2'd1, 8'h00, 8'h81, 8'h81, 4'd3}    // R3 out reg hidden
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, input logic [7:0] exp, input string tag);
    @(negedge clk);
    reg_sel = sel; rd_en = 1'b1;
    #1 check(tag, rdata, exp);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic strobe(input int bit_i);
    @(negedge clk); pc_in[bit_i] = 1'b0;
    repeat (3) @(negedge clk);
    pc_in[bit_i] = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; rd_en = 0; reg_sel = 0; wdata = 0;
    pa_in = 0; pb_in = 0; pc_in = 6'h3F;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state at the pins
    check("R1 pa_oe", {7'd0, pa_oe}, 8'h00);
    check("R1 pb_oe", {7'd0, pb_oe}, 8'h00);
    check("R1 pc_oe", {2'd0, pc_oe}, 8'h00);

    for (int i = 0; i < 12; i++) begin
      logic [30:0] v;
      v = VEC[i];
      @(negedge clk);
      pa_in = v[19:12]; pb_in = ~v[19:12]; pc_in = v[17:12];
      if (!v[30]) wr(v[29:28], v[27:20]);
      else        rd(v[29:28], v[11:4], $sformatf("R%0d vec%0d", v[3:0], i));
    end

    pc_in = 6'h3F;
    repeat (4) @(negedge clk);

    // R2 pins of output ports
    wr(2'd0, 8'h03);
    wr(2'd1, 8'h96);
    wr(2'd2, 8'h69);
    check("R2 pa_out", pa_out, 8'h96);
    check("R2 pa_oe", {7'd0, pa_oe}, 8'h01);
    check("R2 pb_out", pb_out, 8'h69);
    check("R4 mode0 oe", {2'd0, pc_oe}, 8'h00);
    wr(2'd0, 8'h04);
    check("R4 mode1 oe", {2'd0, pc_oe}, 8'h3F);
    wr(2'd0, 8'h08);
    check("R6 mode2 oe", {2'd0, pc_oe}, 8'h3B);
    wr(2'd0, 8'h0C);
    check("R6 mode3 oe", {2'd0, pc_oe}, 8'h1B);

    // R7 strobed input on A with interrupt enabled
    wr(2'd0, 8'h18);
    pa_in = 8'hC3;
    strobe(2);
    pa_in = 8'h11;
    check("R6 A bf pin", {7'd0, pc_out[1]}, 8'h01);
    check("R10 A intr pin", {7'd0, pc_out[0]}, 8'h01);
    rd(2'd0, 8'h07, "R11 status A full");
    rd(2'd1, 8'hC3, "R7 latched byte");
    rd(2'd0, 8'h04, "R8 status cleared");
    check("R8 A pins low", {6'd0, pc_out[1:0]}, 8'h00);

    // R10 no interrupt without enable
    wr(2'd0, 8'h08);
    strobe(2);
    rd(2'd0, 8'h02, "R10 bf only");
    rd(2'd1, 8'h11, "R7 second latch");

    // R9 strobed output on B with interrupt enabled
    wr(2'd0, 8'h2E);
    wr(2'd2, 8'h77);
    rd(2'd0, 8'h30, "R9 write sets bf");
    check("R6 B bf pin", {7'd0, pc_out[4]}, 8'h01);
    check("R9 pb_out", pb_out, 8'h77);
    strobe(5);
    rd(2'd0, 8'h28, "R9 strobe clears bf");
    check("R10 B intr pin", {7'd0, pc_out[3]}, 8'h01);
    wr(2'd2, 8'h78);
    rd(2'd0, 8'h30, "R9 write clears intr");

    // R12 exact latency on A (input handshake, enable off)
    wr(2'd0, 8'h08);
    reg_sel = 2'd0;
    @(negedge clk); pc_in[2] = 1'b0;
    repeat (3) @(negedge clk);
    pc_in[2] = 1'b1;
    @(negedge clk);
    check("R12 edge1", rdata, 8'h00);
    @(negedge clk);
    check("R12 edge2", rdata, 8'h00);
    @(negedge clk);
    check("R12 edge3", rdata, 8'h02);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule